// File: doc/BRIEF.md
# Timed Register Request Gate

This block sits on a register bus between a request source and a single register target. A request may carry a 64-bit execution time. Such a request is captured and held until a free-running system timestamp reaches that time, and is then issued to the target as a one-cycle strobe. A request without a time is captured and issued on the next cycle. The target's acknowledge, status and read data go straight back to the requester.

The timestamp counts samples. Several samples can be handled per clock, so the system time may advance by more than one per cycle. A runtime input therefore sets how many low bits of both timestamps are cleared before they are compared. The timestamp is trusted only on cycles where its valid strobe is high. The block holds one request at a time. It does not produce timestamps, queue commands or report late commands.

Top module: `timed_req_gate`

## Requirements
- R1: An accepted request without a time is issued on the master strobes for exactly one cycle, in the cycle after the clock edge that accepted it.
- R2: An accepted request with its has-time flag set is not issued in any cycle where the masked current time is below its masked target time. It is issued in the first cycle where the masked current time is equal to or above the masked target time and the time-valid strobe is high.
- R3: A held timed request is never issued in a cycle where the time-valid strobe is low, even when its time has been reached.
- R4: Before comparing, the lowest N bits of both the current time and the target time are cleared, where N is the value on the ignore-bits input (0 to 7).
- R5: A timed request whose target time is already in the past when it is accepted is issued in the cycle after acceptance, if time is valid then. It is not dropped.
- R6: The address, data, byte enables, write strobe and read strobe are captured when the request is accepted and are presented unchanged on the master side when it is issued. Changes on the slave inputs after acceptance have no effect.
- R7: A request strobe that arrives while another request is held and not issuing in that cycle is ignored and is never forwarded.
- R8: The slave acknowledge, 2-bit status and 32-bit read data equal the master-side acknowledge, status and read data in the same cycle.
- R9: While reset is high both master strobes are low. Reset discards a held request, so that request is never issued.
- R10: A request that arrives in the same cycle as an issue is accepted, so two untimed requests on consecutive cycles are issued on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| time_now | input | 64 | Current system timestamp |
| time_vld | input | 1 | time_now may be used for comparison this cycle |
| ign_bits | input | 3 | Number of low time bits cleared before comparing |
| s_wr | input | 1 | Write request strobe |
| s_rd | input | 1 | Read request strobe |
| s_addr | input | 20 | Request address |
| s_data | input | 32 | Write data |
| s_be | input | 4 | Byte enables |
| s_has_time | input | 1 | Request carries an execution time |
| s_time | input | 64 | Execution time of the request |
| s_ack | output | 1 | Acknowledge returned to the requester |
| s_status | output | 2 | Status returned to the requester |
| s_rdata | output | 32 | Read data returned to the requester |
| m_wr | output | 1 | Write strobe to the target |
| m_rd | output | 1 | Read strobe to the target |
| m_addr | output | 20 | Address to the target |
| m_data | output | 32 | Write data to the target |
| m_be | output | 4 | Byte enables to the target |
| m_ack | input | 1 | Acknowledge from the target |
| m_status | input | 2 | Status from the target |
| m_rdata | input | 32 | Read data from the target |

## Verification
An untimed request shows up on the master strobes one clock edge after the request strobe, because it passes through a single holding register. A timed request shows up in the same cycle that the time input meets its target. This is possible because the comparison is combinational from the held target to the strobes. The response lines follow the target's lines in the same cycle. The bench drives every input just after a falling edge and samples the outputs one time unit later, before the next rising edge. Its cycle model applies the rule above, so the expected strobes, payload and response are compared against the values driven in that same cycle. Directed cases record the timestamp at which each issue happened and compare it with the time the requirements predict.

// File: rtl/treq_pkg.sv
package treq_pkg;

    // Occupancy of the single request holding slot
    typedef enum logic [1:0] {
        SLOT_EMPTY   = 2'd0,
        SLOT_UNTIMED = 2'd1,
        SLOT_TIMED   = 2'd2
    } slot_e;

endpackage

// File: rtl/treq_time_cmp.sv
module treq_time_cmp #(
    parameter int TIME_W  = 64,
    parameter int SHIFT_W = 3
) (
    input  logic [TIME_W-1:0]  now,
    input  logic               now_vld,
    input  logic [SHIFT_W-1:0] ign,
    input  logic [TIME_W-1:0]  target,
    output logic               reached
);
    logic [TIME_W-1:0] keep_mask;
    logic [TIME_W-1:0] now_m;
    logic [TIME_W-1:0] tgt_m;

    // Clear the low ign bits of both operands
    always_comb begin
        for (int i = 0; i < TIME_W; i++) begin
            keep_mask[i] = (i >= int'(ign));
        end
        now_m   = now & keep_mask;
        tgt_m   = target & keep_mask;
        reached = now_vld && (now_m >= tgt_m);
    end

endmodule

// File: rtl/treq_hold.sv
module treq_hold
    import treq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 32,
    parameter int BE_W   = 4,
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_wr,
    input  logic              s_rd,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [DATA_W-1:0] s_data,
    input  logic [BE_W-1:0]   s_be,
    input  logic              s_has_time,
    input  logic [TIME_W-1:0] s_time,
    output logic [TIME_W-1:0] held_time,
    input  logic              time_reached,
    output logic              m_wr,
    output logic              m_rd,
    output logic [ADDR_W-1:0] m_addr,
    output logic [DATA_W-1:0] m_data,
    output logic [BE_W-1:0]   m_be
);
    typedef struct packed {
        slot_e             slot;
        logic              wr;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
        logic [TIME_W-1:0] ttime;
    } hold_t;

    hold_t hold_d, hold_q;
    logic  go;
    logic  accept;

    always_comb begin
        hold_d = hold_q;
        go     = (hold_q.slot == SLOT_UNTIMED) ||
                 ((hold_q.slot == SLOT_TIMED) && time_reached);
        accept = (s_wr || s_rd) && ((hold_q.slot == SLOT_EMPTY) || go);
        if (accept) begin
            hold_d.slot  = s_has_time ? SLOT_TIMED : SLOT_UNTIMED;
            hold_d.wr    = s_wr;
            hold_d.rd    = s_rd;
            hold_d.addr  = s_addr;
            hold_d.data  = s_data;
            hold_d.be    = s_be;
            hold_d.ttime = s_time;
        end else if (go) begin
            hold_d.slot  = SLOT_EMPTY;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q      <= '0;
            hold_q.slot <= SLOT_EMPTY;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign held_time = hold_q.ttime;
    assign m_wr      = go && hold_q.wr && !rst;
    assign m_rd      = go && hold_q.rd && !rst;
    assign m_addr    = hold_q.addr;
    assign m_data    = hold_q.data;
    assign m_be      = hold_q.be;

    // R1: an untimed request is issued on the next cycle
    a_r1_untimed_next: assert property (@(posedge clk) disable iff (rst)
        (accept && !s_has_time) |=> (m_wr || m_rd));

    // R6: payload stays put while a request waits
    a_r6_hold_stable: assert property (@(posedge clk) disable iff (rst)
        ((hold_q.slot != SLOT_EMPTY) && !go) |=>
            ($stable(m_addr) && $stable(m_data) && $stable(m_be)));

    // R7: an issue lasts one cycle unless a new request came in
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        ((m_wr || m_rd) && !(s_wr || s_rd)) |=> !(m_wr || m_rd));

    // R9: nothing is issued in the first cycle after reset
    a_r9_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!m_wr && !m_rd));

endmodule

// File: rtl/timed_req_gate.sv
module timed_req_gate #(
    parameter int ADDR_W   = 20,
    parameter int DATA_W   = 32,
    parameter int TIME_W   = 64,
    parameter int SHIFT_W  = 3,
    parameter int STATUS_W = 2,
    localparam int BE_W    = DATA_W / 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [TIME_W-1:0]   time_now,
    input  logic                time_vld,
    input  logic [SHIFT_W-1:0]  ign_bits,
    input  logic                s_wr,
    input  logic                s_rd,
    input  logic [ADDR_W-1:0]   s_addr,
    input  logic [DATA_W-1:0]   s_data,
    input  logic [BE_W-1:0]     s_be,
    input  logic                s_has_time,
    input  logic [TIME_W-1:0]   s_time,
    output logic                s_ack,
    output logic [STATUS_W-1:0] s_status,
    output logic [DATA_W-1:0]   s_rdata,
    output logic                m_wr,
    output logic                m_rd,
    output logic [ADDR_W-1:0]   m_addr,
    output logic [DATA_W-1:0]   m_data,
    output logic [BE_W-1:0]     m_be,
    input  logic                m_ack,
    input  logic [STATUS_W-1:0] m_status,
    input  logic [DATA_W-1:0]   m_rdata
);
    logic [TIME_W-1:0] held_time;
    logic              time_reached;

    treq_time_cmp #(
        .TIME_W  (TIME_W),
        .SHIFT_W (SHIFT_W)
    ) u_cmp (
        .now     (time_now),
        .now_vld (time_vld),
        .ign     (ign_bits),
        .target  (held_time),
        .reached (time_reached)
    );

    treq_hold #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BE_W   (BE_W),
        .TIME_W (TIME_W)
    ) u_hold (
        .clk          (clk),
        .rst          (rst),
        .s_wr         (s_wr),
        .s_rd         (s_rd),
        .s_addr       (s_addr),
        .s_data       (s_data),
        .s_be         (s_be),
        .s_has_time   (s_has_time),
        .s_time       (s_time),
        .held_time    (held_time),
        .time_reached (time_reached),
        .m_wr         (m_wr),
        .m_rd         (m_rd),
        .m_addr       (m_addr),
        .m_data       (m_data),
        .m_be         (m_be)
    );

    // Response path back to the requester
    assign s_ack    = m_ack;
    assign s_status = m_status;
    assign s_rdata  = m_rdata;

    // R3: without valid time only a just-accepted untimed request may issue
    a_r3_no_issue_invalid_time: assert property (@(posedge clk) disable iff (rst)
        ((m_wr || m_rd) && !time_vld) |-> $past((s_wr || s_rd) && !s_has_time));

endmodule

// File: tb/timed_req_gate_test.sv
module timed_req_gate_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] time_now;
    logic        time_vld;
    logic [2:0]  ign_bits;
    logic        s_wr, s_rd, s_has_time;
    logic [19:0] s_addr;
    logic [31:0] s_data;
    logic [3:0]  s_be;
    logic [63:0] s_time;
    logic        s_ack;
    logic [1:0]  s_status;
    logic [31:0] s_rdata;
    logic        m_wr, m_rd;
    logic [19:0] m_addr;
    logic [31:0] m_data;
    logic [3:0]  m_be;
    logic        m_ack;
    logic [1:0]  m_status;
    logic [31:0] m_rdata;

    timed_req_gate uut (
        .clk(clk), .rst(rst), .time_now(time_now), .time_vld(time_vld),
        .ign_bits(ign_bits), .s_wr(s_wr), .s_rd(s_rd), .s_addr(s_addr),
        .s_data(s_data), .s_be(s_be), .s_has_time(s_has_time), .s_time(s_time),
        .s_ack(s_ack), .s_status(s_status), .s_rdata(s_rdata),
        .m_wr(m_wr), .m_rd(m_rd), .m_addr(m_addr), .m_data(m_data), .m_be(m_be),
        .m_ack(m_ack), .m_status(m_status), .m_rdata(m_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;

    // stimulus for the next cycle
    logic        b_rst = 1'b1, b_vld = 1'b1, b_wr = 1'b0, b_rd = 1'b0, b_ht = 1'b0;
    logic [63:0] b_now = '0, b_t = '0;
    logic [2:0]  b_ign = '0;
    logic [19:0] b_addr = '0;
    logic [31:0] b_data = '0;
    logic [3:0]  b_be = '0;

    // cycle model
    logic        mp = 1'b0, mt = 1'b0, mwr = 1'b0, mrd = 1'b0;
    logic [63:0] mtime = '0;
    logic [19:0] maddr = '0;
    logic [31:0] mdata = '0;
    logic [3:0]  mbe = '0;

    int          issued = 0;
    logic [19:0] last_addr = '0;
    logic [63:0] last_now = '0;

    function automatic logic reach(logic [63:0] now, logic [63:0] t, logic [2:0] ign);
        logic [63:0] msk;
        msk = ~((64'd1 << ign) - 64'd1);
        return (now & msk) >= (t & msk);
    endfunction

    task automatic check(input logic ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        logic  exp_go, acc;
        string tag;
        @(negedge clk);
        rst = b_rst; time_now = b_now; time_vld = b_vld; ign_bits = b_ign;
        s_wr = b_wr; s_rd = b_rd; s_addr = b_addr; s_data = b_data; s_be = b_be;
        s_has_time = b_ht; s_time = b_t;
        m_ack = 1'($urandom); m_status = 2'($urandom); m_rdata = $urandom;
        #1;
        exp_go = !b_rst && mp && (!mt || (b_vld && reach(b_now, mtime, b_ign)));
        tag = b_rst ? "R9" : (!mp ? "R7" : (!mt ? "R1" : (!b_vld ? "R3" : "R2")));
        check(m_wr === (exp_go && mwr), tag, 64'(m_wr), 64'(exp_go && mwr));
        check(m_rd === (exp_go && mrd), tag, 64'(m_rd), 64'(exp_go && mrd));
        if (exp_go) begin
            check({m_addr, m_data, m_be} === {maddr, mdata, mbe}, "R6",
                  64'({m_addr, m_data, m_be}), 64'({maddr, mdata, mbe}));
            issued++;
            last_addr = m_addr;
            last_now  = b_now;
        end
        check({s_ack, s_status, s_rdata} === {m_ack, m_status, m_rdata}, "R8",
              64'({s_ack, s_status, s_rdata}), 64'({m_ack, m_status, m_rdata}));
        if (b_rst) begin
            mp = 1'b0;
        end else begin
            acc = (b_wr || b_rd) && (!mp || exp_go);
            if (acc) begin
                mp = 1'b1; mt = b_ht; mtime = b_t; mwr = b_wr; mrd = b_rd;
                maddr = b_addr; mdata = b_data; mbe = b_be;
            end else if (exp_go) begin
                mp = 1'b0;
            end
        end
        b_now = b_now + 64'd1;
    endtask

    task automatic req(input logic wr, input logic rd, input logic [19:0] a,
                       input logic ht, input logic [63:0] t);
        b_wr = wr; b_rd = rd; b_addr = a; b_data = $urandom; b_be = 4'($urandom);
        b_ht = ht; b_t = t;
        step();
        b_wr = 1'b0; b_rd = 1'b0; b_addr = 20'($urandom); b_data = $urandom;
    endtask

    task automatic run_to(input logic [63:0] stop);
        while (b_now != stop) step();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int base;
        void'($urandom(32'h5eed_0a17));
        // reset state (R9)
        repeat (3) step();
        b_rst = 1'b0;

        // R1 untimed write
        base = issued; b_now = 0;
        req(1'b1, 1'b0, 20'h12345, 1'b0, '0);
        step();
        check(issued == base + 1 && last_addr == 20'h12345, "R1",
              64'(last_addr), 64'h12345);

        // R2 timed read waits exactly until its time
        base = issued; b_now = 90;
        req(1'b0, 1'b1, 20'h00abc, 1'b1, 64'd100);
        run_to(64'd103);
        check(issued == base + 1 && last_now == 64'd100, "R2", last_now, 64'd100);

        // R3 valid strobe low delays the issue
        base = issued; b_now = 200;
        req(1'b1, 1'b0, 20'h00200, 1'b1, 64'd205);
        b_vld = 1'b0; run_to(64'd210);
        b_vld = 1'b1; run_to(64'd213);
        check(issued == base + 1 && last_now == 64'd210, "R3", last_now, 64'd210);

        // R4 ignored low bits make 0x301 match target 0x303
        base = issued; b_now = 64'h300; b_ign = 3'd2;
        req(1'b1, 1'b0, 20'h00300, 1'b1, 64'h303);
        run_to(64'h306);
        check(issued == base + 1 && last_now == 64'h301, "R4", last_now, 64'h301);
        base = issued; b_now = 64'h400; b_ign = 3'd0;
        req(1'b1, 1'b0, 20'h00400, 1'b1, 64'h403);
        run_to(64'h406);
        check(issued == base + 1 && last_now == 64'h403, "R4", last_now, 64'h403);

        // R5 past time issues at once
        base = issued; b_now = 1000;
        req(1'b0, 1'b1, 20'h01000, 1'b1, 64'd10);
        step();
        check(issued == base + 1 && last_now == 64'd1001, "R5", last_now, 64'd1001);

        // R7 second strobe during a hold is dropped
        base = issued; b_now = 2000;
        req(1'b1, 1'b0, 20'h0aaaa, 1'b1, 64'd2010);
        run_to(64'd2003);
        req(1'b1, 1'b0, 20'h0bbbb, 1'b0, '0);
        run_to(64'd2015);
        check(issued == base + 1 && last_addr == 20'h0aaaa, "R7",
              64'(last_addr), 64'h0aaaa);

        // R9 reset discards a held request
        base = issued; b_now = 3000;
        req(1'b1, 1'b0, 20'h0cccc, 1'b1, 64'd3005);
        step();
        b_rst = 1'b1; step(); b_rst = 1'b0;
        run_to(64'd3010);
        check(issued == base, "R9", 64'(issued - base), 64'd0);

        // R10 back-to-back untimed requests
        base = issued; b_now = 4000;
        req(1'b1, 1'b0, 20'h0d001, 1'b0, '0);
        req(1'b0, 1'b1, 20'h0d002, 1'b0, '0);
        step();
        check(issued == base + 2 && last_addr == 20'h0d002 && last_now == 64'd4002,
              "R10", 64'(last_addr), 64'h0d002);

        // constrained random traffic against the cycle model
        for (int n = 0; n < 3000; n++) begin
            b_vld = ($urandom_range(0, 9) != 0);
            if (($urandom_range(0, 15)) == 0) b_ign = 3'($urandom_range(0, 3));
            b_rst = ($urandom_range(0, 199) == 0);
            if ($urandom_range(0, 9) < 3) begin
                b_wr = 1'($urandom); b_rd = !b_wr || 1'($urandom);
                b_addr = 20'($urandom); b_data = $urandom; b_be = 4'($urandom);
                b_ht = 1'($urandom);
                b_t = b_now + 64'($urandom_range(0, 48)) - 64'd8;
            end else begin
                b_wr = 1'b0; b_rd = 1'b0;
                b_addr = 20'($urandom); b_data = $urandom; b_ht = 1'($urandom);
                b_t = $urandom;
            end
            step();
        end
        b_rst = 1'b0; b_wr = 1'b0; b_rd = 1'b0;
        repeat (2) step();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule